// File: doc/BRIEF.md
# Run-Time Resizable Word FIFO

This block is a single-clock first-in first-out buffer for 32-bit words. A serial controller uses one copy on its transmit path and one on its receive path. The storage always holds 32 words, but the number of entries the FIFO accepts before it reports full is chosen while the block is running.

In small mode the usable depth is four entries. In big mode the depth follows the configured frame width:

- narrow frames get 32 entries;
- medium frames get 16 entries;
- wide frames get 8 entries.

The usable depth is registered, so a change of mode or frame width takes effect on the following clock edge. Entries that are already held survive the change.

Alongside the data path the block reports five things:

- occupancy;
- empty;
- full;
- a warning one entry before full;
- a warning when a single entry remains.

A synchronous flush discards all content. A write into a full FIFO is refused and changes nothing. A read from an empty FIFO returns zero.

Top module: `adaptive_depth_fifo`

## Requirements
- R1: After reset, `level_o` is 0, `empty_o` is 1, `almost_empty_o`, `almost_full_o` and `full_o` are 0, `pop_data_o` is 0, and the usable depth is 4.
- R2: With `big_mode_i` = 0, the usable depth is 4 whatever `frame_len_i` holds: the fourth accepted push sets `full_o`.
- R3: With `big_mode_i` = 1, the usable depth depends on `frame_len_i`:
  - 32 when `frame_len_i` ≤ 8;
  - 16 when `frame_len_i` is 9 to 16;
  - 8 when `frame_len_i` ≥ 17.
- R4: A push while `level_o` is at or above the usable depth is refused: `level_o` is unchanged and the held words and their order are unchanged.
- R5: `almost_full_o` is 1 exactly when `level_o` equals the usable depth minus one. `full_o` is 1 when `level_o` is at or above the usable depth.
- R6: `almost_empty_o` is 1 exactly when `level_o` is 1.
- R7: `empty_o` clears after any accepted push and sets again after the pop that removes the last entry.
- R8: A pop while empty loads 0 into `pop_data_o` and does not change the occupancy.
- R9: `flush_i` empties the FIFO on the next edge: `level_o` becomes 0, `empty_o` becomes 1 and `full_o` becomes 0. A push or pop in the same cycle as a flush is dropped.
- R10: A change of `big_mode_i` or `frame_len_i` takes effect on the next edge. The held entries and `level_o` are kept, and `full_o` is evaluated against the new depth, so a shrink below the occupancy shows full and refuses pushes.
- R11: Words leave in the order they were accepted. A push and a pop in the same cycle leave `level_o` unchanged.
- R12: `pop_data_o` is registered. It loads the oldest word on the edge of an accepted pop and holds its value in cycles without a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous discard of all entries |
| big_mode_i | input | 1 | 1 selects depth from frame width, 0 selects four entries |
| frame_len_i | input | 6 | Configured frame width in bits |
| push_i | input | 1 | Write request |
| push_data_i | input | 32 | Word to write |
| pop_i | input | 1 | Read request |
| pop_data_o | output | 32 | Word read by the last pop (0 if that pop found the FIFO empty) |
| level_o | output | 6 | Current occupancy |
| empty_o | output | 1 | No entries held |
| almost_empty_o | output | 1 | Exactly one entry held |
| almost_full_o | output | 1 | One entry short of the usable depth |
| full_o | output | 1 | Occupancy at or above the usable depth |

## Verification
The bench fills the FIFO to one past its usable depth at every depth boundary: frame widths 8, 9, 16, 17 and 32 in big mode, and small mode with a narrow frame.

A depth decoder with an off-by-one frame threshold shows up as `full_o` at the wrong count. A push check that ignores full shows up as a fifth or thirty-third word in the drained data. The bench also shrinks the depth from 32 to 4 while six words are held. A design that drops entries or recomputes occupancy on that change fails the drain order, and one that compares for equality instead of at-or-above misses full.

Pops from empty, flush combined with a push, and push-with-pop streaming each target a distinct fault: a stale word returned instead of zero, a surviving write, or a level that drifts.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned PHYS_DEPTH  = 32;
  localparam int unsigned SMALL_DEPTH = 4;
  localparam int unsigned FRAME_W     = 6;
  localparam int unsigned NARROW_MAX  = 8;
  localparam int unsigned MID_MAX     = 16;
endpackage

// File: rtl/afd_depth_sel.sv
module afd_depth_sel #(
  parameter int unsigned FRAME_W     = 6,
  parameter int unsigned LVL_W       = 6,
  parameter int unsigned PHYS_DEPTH  = 32,
  parameter int unsigned SMALL_DEPTH = 4,
  parameter int unsigned NARROW_MAX  = 8,
  parameter int unsigned MID_MAX     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               big_mode_i,
  input  logic [FRAME_W-1:0] frame_len_i,
  output logic [LVL_W-1:0]   depth_o
);
  localparam logic [LVL_W-1:0] D_SMALL  = LVL_W'(SMALL_DEPTH);
  localparam logic [LVL_W-1:0] D_NARROW = LVL_W'(PHYS_DEPTH);
  localparam logic [LVL_W-1:0] D_MID    = LVL_W'(PHYS_DEPTH / 2);
  localparam logic [LVL_W-1:0] D_WIDE   = LVL_W'(PHYS_DEPTH / 4);

  logic [LVL_W-1:0] depth_d, depth_q;

  always_comb begin
    if (!big_mode_i)                              depth_d = D_SMALL;
    else if (frame_len_i <= FRAME_W'(NARROW_MAX)) depth_d = D_NARROW;
    else if (frame_len_i <= FRAME_W'(MID_MAX))    depth_d = D_MID;
    else                                          depth_d = D_WIDE;
  end

  // registered so a config change applies one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= D_SMALL;
    else         depth_q <= depth_d;
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/afd_store.sv
module afd_store #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PHYS_DEPTH = 32,
  parameter int unsigned PTR_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [PHYS_DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;

  // power-of-two storage: pointers wrap naturally, independent of usable depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/afd_flags.sv
module afd_flags #(
  parameter int unsigned LVL_W = 6
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] depth_i,
  output logic             empty_o,
  output logic             almost_empty_o,
  output logic             almost_full_o,
  output logic             full_o,
  output logic             can_push_o
);
  logic [LVL_W-1:0] depth_m1;

  assign depth_m1       = depth_i - 1'b1;
  assign empty_o        = (level_i == '0);
  assign almost_empty_o = (level_i == LVL_W'(1));
  assign almost_full_o  = (level_i == depth_m1);
  // at-or-above: occupancy may exceed depth after a shrink
  assign full_o         = (level_i >= depth_i);
  assign can_push_o     = (level_i < depth_i);
endmodule

// File: rtl/adaptive_depth_fifo.sv
module adaptive_depth_fifo
  import afd_pkg::*;
#(
  parameter int unsigned DATA_W  = WORD_W,
  parameter int unsigned DEPTH   = PHYS_DEPTH,
  parameter int unsigned SMALL_D = SMALL_DEPTH,
  parameter int unsigned FLEN_W  = FRAME_W,
  parameter int unsigned NAR_MAX = NARROW_MAX,
  parameter int unsigned MED_MAX = MID_MAX,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              big_mode_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              empty_o,
  output logic              almost_empty_o,
  output logic              almost_full_o,
  output logic              full_o
);
  logic [LVL_W-1:0]  depth_q, level_q;
  logic [DATA_W-1:0] head, pop_data_q;
  logic              can_push, push_ok, pop_ok;

  afd_depth_sel #(
    .FRAME_W(FLEN_W), .LVL_W(LVL_W), .PHYS_DEPTH(DEPTH),
    .SMALL_DEPTH(SMALL_D), .NARROW_MAX(NAR_MAX), .MID_MAX(MED_MAX)
  ) u_depth (
    .clk_i(clk_i), .rst_ni(rst_ni), .big_mode_i(big_mode_i),
    .frame_len_i(frame_len_i), .depth_o(depth_q)
  );

  afd_flags #(.LVL_W(LVL_W)) u_flags (
    .level_i(level_q), .depth_i(depth_q), .empty_o(empty_o),
    .almost_empty_o(almost_empty_o), .almost_full_o(almost_full_o),
    .full_o(full_o), .can_push_o(can_push)
  );

  assign push_ok = push_i & can_push & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;

  afd_store #(.WORD_W(DATA_W), .PHYS_DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_en_i(push_ok), .wr_data_i(push_data_i),
    .rd_en_i(pop_ok), .rd_data_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (flush_i) begin
      level_q <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pop_data_q <= '0;
    else if (pop_i && !flush_i)  pop_data_q <= pop_ok ? head : '0;
  end

  assign pop_data_o = pop_data_q;
  assign level_o    = level_q;
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned DEPTH  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              empty_o,
  input logic              almost_empty_o,
  input logic              almost_full_o,
  input logic              full_o
);
  assert_full_blocks_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(level_o));

  assert_push_clears_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !flush_i) |=> !empty_o);

  assert_empty_pop_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !flush_i) |=> (pop_data_o == '0));

  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !full_o && level_o == '0));

  assert_flags_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({empty_o, almost_empty_o, almost_full_o, full_o}));

  assert_level_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  assert_pop_data_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(pop_data_o));
endmodule

bind adaptive_depth_fifo afd_checker #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .DEPTH(DEPTH)
) u_afd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .push_i(push_i),
  .pop_i(pop_i), .pop_data_o(pop_data_o), .level_o(level_o),
  .empty_o(empty_o), .almost_empty_o(almost_empty_o),
  .almost_full_o(almost_full_o), .full_o(full_o)
);

// File: tb/adaptive_depth_fifo_tb_top.sv
module adaptive_depth_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, big_mode_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [5:0]  frame_len_i = 6'd8;
  logic [31:0] push_data_i = '0;
  logic [31:0] pop_data_o;
  logic [5:0]  level_o;
  logic        empty_o, almost_empty_o, almost_full_o, full_o;

  int n_chk = 0, n_fail = 0;
  int mdl_depth = 4;
  logic [31:0] mdl[$];
  logic [31:0] exp_q[$];
  logic [31:0] last_pop = '0;
  bit done = 0;

  always #5 clk = ~clk;

  adaptive_depth_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .big_mode_i(big_mode_i),
    .frame_len_i(frame_len_i), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .level_o(level_o),
    .empty_o(empty_o), .almost_empty_o(almost_empty_o),
    .almost_full_o(almost_full_o), .full_o(full_o)
  );

  function automatic int exp_depth(input logic big, input int flen);
    if (!big) return 4;
    if (flen <= 8) return 32;
    if (flen <= 16) return 16;
    return 8;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each pop result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      if (rst_ni && pop_i && !flush_i) begin
        logic [31:0] e;
        #1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
        chk("R11 pop order", pop_data_o, e);
      end
    end
  end

  task automatic cyc(input logic p, input logic [31:0] d, input logic q, input logic f);
    bit acc;
    @(negedge clk);
    push_i = p; push_data_i = d; pop_i = q; flush_i = f;
    if (f) mdl.delete();
    else begin
      acc = p && (mdl.size() < mdl_depth);
      if (q) begin
        last_pop = (mdl.size() > 0) ? mdl.pop_front() : 32'h0;
        exp_q.push_back(last_pop);
      end
      if (acc) mdl.push_back(d);
    end
    @(posedge clk); #1;
    push_i = 0; pop_i = 0; flush_i = 0;
  endtask

  task automatic set_mode(input logic big, input logic [5:0] flen);
    @(negedge clk);
    big_mode_i = big; frame_len_i = flen;
    @(posedge clk); #1;
    mdl_depth = exp_depth(big, flen);
  endtask

  task automatic fill_drain(input int dep, input string tag);
    for (int i = 0; i <= dep; i++) begin
      cyc(1, 32'hA000_0000 + (dep << 8) + i, 0, 0);
      if (i == dep - 2) chk({tag, " R5 almost_full"}, almost_full_o, 1);
      if (i == dep - 1) chk({tag, " R5 full at depth"}, full_o, 1);
    end
    chk({tag, " R4 level held at depth"}, level_o, dep);
    for (int i = 0; i < dep; i++) cyc(0, 0, 1, 0);
    chk({tag, " R7 empty after drain"}, empty_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    #1;
    chk("R1 level", level_o, 0);
    chk("R1 empty", empty_o, 1);
    chk("R1 flags", {almost_empty_o, almost_full_o, full_o}, 0);
    chk("R1 pop_data", pop_data_o, 0);

    // small mode, depth 4
    for (int i = 0; i < 5; i++) begin
      cyc(1, 32'h1000 + i, 0, 0);
      if (i == 0) chk("R7 empty clears", empty_o, 0);
      if (i == 0) chk("R6 almost_empty", almost_empty_o, 1);
      if (i == 2) chk("R5 almost_full small", almost_full_o, 1);
      if (i == 3) chk("R2 full at 4", full_o, 1);
    end
    chk("R4 fifth push refused", level_o, 4);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1, 0);
      if (i == 2) chk("R6 one left", almost_empty_o, 1);
    end
    chk("R7 empty after last pop", empty_o, 1);
    cyc(0, 0, 1, 0);
    chk("R8 pop empty zero", pop_data_o, 0);
    chk("R8 level unchanged", level_o, 0);

    // R12 hold
    cyc(1, 32'h5A5A, 0, 0);
    cyc(0, 0, 1, 0);
    repeat (2) cyc(0, 0, 0, 0);
    chk("R12 pop_data holds", pop_data_o, last_pop);

    // depth boundaries
    set_mode(0, 6'd8);  fill_drain(4, "R2 small f8");
    set_mode(1, 6'd8);  fill_drain(32, "R3 f8");
    set_mode(1, 6'd9);  fill_drain(16, "R3 f9");
    set_mode(1, 6'd16); fill_drain(16, "R3 f16");
    set_mode(1, 6'd17); fill_drain(8, "R3 f17");
    set_mode(1, 6'd32); fill_drain(8, "R3 f32");

    // R11 streaming push and pop
    set_mode(1, 6'd8);
    cyc(1, 32'h2000, 0, 0);
    cyc(1, 32'h2001, 0, 0);
    for (int i = 2; i < 7; i++) begin
      cyc(1, 32'h2000 + i, 1, 0);
      chk("R11 level steady", level_o, 2);
    end
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);

    // R9 flush with push
    for (int i = 0; i < 3; i++) cyc(1, 32'h3000 + i, 0, 0);
    cyc(1, 32'h3FFF, 0, 1);
    chk("R9 flush level", level_o, 0);
    chk("R9 flush empty", empty_o, 1);
    chk("R9 flush not full", full_o, 0);
    cyc(1, 32'h3100, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R9 no stale data", pop_data_o, 32'h3100);

    // R10 shrink with entries held
    for (int i = 0; i < 6; i++) cyc(1, 32'h4000 + i, 0, 0);
    set_mode(0, 6'd8);
    chk("R10 full after shrink", full_o, 1);
    chk("R10 level kept", level_o, 6);
    cyc(1, 32'h4FFF, 0, 0);
    chk("R10 push refused", level_o, 6);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    chk("R10 still full at 4", full_o, 1);
    cyc(0, 0, 1, 0);
    chk("R10 almost_full at 3", almost_full_o, 1);
    chk("R10 not full at 3", full_o, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    chk("R10 empty after drain", empty_o, 1);

    repeat (3) cyc(0, 0, 0, 0);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule